// File: doc/BRIEF.md
# Segment Access Protection Checker

This block decides whether a single memory access may go ahead through a segment whose descriptor is already held in a cache. The block takes the access kind, the offset, the access size and the descriptor fields. It also takes the current privilege level, the protection-enable bit and the virtual-8086 flag. It returns the linear address of the access. If the access breaks a rule, it also returns a fault, marked either as a general-protection fault or as a not-present fault.

The evaluation itself is pure logic. The verdict and the address are captured in registers on the clock edge where `req_valid` is high. From the following cycle they are presented together with a one-cycle `rsp_valid` pulse. Requests may be issued back to back, one per cycle. Between requests the outputs keep the last verdict.

Top module: `seg_access_guard`

## Requirements
- R1: On reset, `rsp_valid`, `fault`, `fault_np` and `lin_addr` are all zero. The result of a request seen on a rising edge with `req_valid` high is presented after that edge, with `rsp_valid` high for exactly that cycle. When `req_valid` is low, `rsp_valid` is low and the other outputs hold their values.
- R2: `lin_addr` equals `seg_base + offset` modulo 2^32.
- R3: Three kinds of access use the normal limit test: an instruction fetch, any access to an executable segment, and any access to a segment with `seg_dir` low. For these, a general-protection fault is raised when `offset + acc_size - 1` is greater than `seg_limit`. The sum is formed without wrap-around, and ending exactly at the limit is allowed.
- R4: A data read or write to a non-executable segment with `seg_dir` high uses the expand-down test. It faults with general protection when `offset < seg_limit`. An offset equal to the limit is allowed.
- R5: When `prot_en` is 0 or `v86` is 1, only the limit test is applied. Presence, privilege and type never cause a fault in that case.
- R6: With protection active, a segment with `seg_present` low gives a fault with `fault_np` = 1. This is reported in place of any privilege or type violation. A limit violation still takes precedence and is reported as general protection (`fault_np` = 0).
- R7: With protection active, a data read or write faults with general protection if `seg_rpl > seg_dpl` or `cpl > seg_dpl`. An instruction fetch faults only on `cpl > seg_dpl`.
- R8: With protection active, a fetch from a segment with `seg_exec` low faults. A read from an executable segment with `seg_rw` low faults. A read from a data segment is allowed whatever the value of `seg_rw`.
- R9: With protection active, every write to an executable segment faults. A write to a data segment with `seg_rw` low also faults. Both are general-protection faults.
- R10: `acc_kind` encodes 0 = instruction fetch, 1 = data read, 2 = data write. Code 3 is handled exactly like a data write.
- R11: An access that passes every applicable test gives `fault` = 0 and `fault_np` = 0. `fault_np` is never 1 while `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Evaluate the presented access on this edge |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 write |
| offset | input | 32 | Offset within the segment |
| acc_size | input | 3 | Access size in bytes (1 or more) |
| seg_base | input | 32 | Descriptor base |
| seg_limit | input | 32 | Descriptor limit (byte granular) |
| seg_present | input | 1 | Descriptor present bit |
| seg_dpl | input | 2 | Descriptor privilege level |
| seg_rpl | input | 2 | Requested privilege level of the selector |
| seg_exec | input | 1 | Segment is code |
| seg_rw | input | 1 | Readable (code) or writable (data) |
| seg_dir | input | 1 | Expand-down (data) or conforming (code) |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 mode active |
| rsp_valid | output | 1 | Result valid pulse |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access rejected |
| fault_np | output | 1 | 1 = not-present fault, 0 = general-protection fault |

## Verification
The bench sweeps every access kind against all combinations of the type bits, presence, and the privilege levels. It runs each combination in three protection modes and at four offset and limit positions around the limit. The offset positions are chosen so that ending exactly at the limit, going one byte over it, and sitting exactly at an expand-down limit all occur. A design that used `<=` in place of `<`, or that dropped the `-1` in the end-of-access sum, would flag or pass these boundary accesses wrongly. Checking presence before the limit would report not-present where general protection is due, and applying the RPL test to fetches would fault legal code fetches. Separate directed accesses cover an offset near 2^32 that must not wrap past the limit, an address that wraps modulo 2^32, and outputs that stay unchanged while no request is issued.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH     = 2'd0,
    ACC_READ      = 2'd1,
    ACC_WRITE     = 2'd2,
    ACC_WRITE_ALT = 2'd3
  } acc_kind_e;

  // Outcome of the ordered checks before registering.
  typedef struct packed {
    logic fault;
    logic np;
  } verdict_t;
endpackage

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic [AW-1:0] offset,
  input  logic [SW-1:0] acc_size,
  input  logic [AW-1:0] seg_limit,
  input  logic          down_mode,
  output logic          over
);
  localparam int EW = AW + 1;

  logic [EW-1:0] last_byte;

  always_comb begin
    // One extra bit keeps the end-of-access sum from wrapping.
    last_byte = {1'b0, offset} + EW'(acc_size) - EW'(1);
    if (down_mode) begin
      over = offset < seg_limit;
    end else begin
      over = last_byte > {1'b0, seg_limit};
    end
  end
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check #(
  parameter int PLW = 2
) (
  input  logic           is_fetch,
  input  logic           is_read,
  input  logic           is_write,
  input  logic           seg_present,
  input  logic [PLW-1:0] seg_dpl,
  input  logic [PLW-1:0] seg_rpl,
  input  logic [PLW-1:0] cpl,
  input  logic           seg_exec,
  input  logic           seg_rw,
  output logic           np_fail,
  output logic           priv_fail,
  output logic           type_fail
);
  logic cpl_low;
  logic rpl_low;

  always_comb begin
    np_fail   = !seg_present;
    cpl_low   = cpl > seg_dpl;
    rpl_low   = seg_rpl > seg_dpl;
    // The selector's requested level does not gate code fetches.
    priv_fail = cpl_low || (!is_fetch && rpl_low);
    type_fail = (is_fetch && !seg_exec)
             || (is_read && seg_exec && !seg_rw)
             || (is_write && (seg_exec || !seg_rw));
  end
endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
  import seg_guard_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d_addr,
  input  verdict_t      d_verdict,
  output logic          q_valid,
  output logic [AW-1:0] q_addr,
  output verdict_t      q_verdict
);
  logic          valid_nx;
  logic [AW-1:0] addr_nx;
  verdict_t      verdict_nx;

  always_comb begin
    valid_nx   = load;
    addr_nx    = q_addr;
    verdict_nx = q_verdict;
    if (load) begin
      addr_nx    = d_addr;
      verdict_nx = d_verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_addr    <= '0;
      q_verdict <= '0;
    end else begin
      q_valid   <= valid_nx;
      q_addr    <= addr_nx;
      q_verdict <= verdict_nx;
    end
  end
endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
  import seg_guard_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SW  = 3,
  parameter int PLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     acc_kind,
  input  logic [AW-1:0]  offset,
  input  logic [SW-1:0]  acc_size,
  input  logic [AW-1:0]  seg_base,
  input  logic [AW-1:0]  seg_limit,
  input  logic           seg_present,
  input  logic [PLW-1:0] seg_dpl,
  input  logic [PLW-1:0] seg_rpl,
  input  logic           seg_exec,
  input  logic           seg_rw,
  input  logic           seg_dir,
  input  logic [PLW-1:0] cpl,
  input  logic           prot_en,
  input  logic           v86,
  output logic           rsp_valid,
  output logic [AW-1:0]  lin_addr,
  output logic           fault,
  output logic           fault_np
);
  acc_kind_e kind;
  logic      is_fetch;
  logic      is_read;
  logic      is_write;
  logic      down_mode;
  logic      prot_live;
  logic      lim_over;
  logic      np_fail;
  logic      priv_fail;
  logic      type_fail;
  logic [AW-1:0] addr_c;
  verdict_t  verdict_c;
  verdict_t  verdict_q;

  always_comb begin
    kind      = acc_kind_e'(acc_kind);
    is_fetch  = kind == ACC_FETCH;
    is_read   = kind == ACC_READ;
    is_write  = (kind == ACC_WRITE) || (kind == ACC_WRITE_ALT);
    down_mode = !is_fetch && !seg_exec && seg_dir;
    prot_live = prot_en && !v86;
    addr_c    = seg_base + offset;
  end

  seg_limit_check #(.AW(AW), .SW(SW)) u_limit (
    .offset    (offset),
    .acc_size  (acc_size),
    .seg_limit (seg_limit),
    .down_mode (down_mode),
    .over      (lim_over)
  );

  seg_prot_check #(.PLW(PLW)) u_prot (
    .is_fetch    (is_fetch),
    .is_read     (is_read),
    .is_write    (is_write),
    .seg_present (seg_present),
    .seg_dpl     (seg_dpl),
    .seg_rpl     (seg_rpl),
    .cpl         (cpl),
    .seg_exec    (seg_exec),
    .seg_rw      (seg_rw),
    .np_fail     (np_fail),
    .priv_fail   (priv_fail),
    .type_fail   (type_fail)
  );

  // Ordered arbitration: limit, presence, privilege, type.
  always_comb begin
    verdict_c = '0;
    if (lim_over) begin
      verdict_c.fault = 1'b1;
    end else if (prot_live) begin
      if (np_fail) begin
        verdict_c.fault = 1'b1;
        verdict_c.np    = 1'b1;
      end else if (priv_fail || type_fail) begin
        verdict_c.fault = 1'b1;
      end
    end
  end

  seg_result_reg #(.AW(AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_valid),
    .d_addr    (addr_c),
    .d_verdict (verdict_c),
    .q_valid   (rsp_valid),
    .q_addr    (lin_addr),
    .q_verdict (verdict_q)
  );

  assign fault    = verdict_q.fault;
  assign fault_np = verdict_q.np;
endmodule

// File: rtl/seg_access_guard_checker.sv
module seg_access_guard_checker #(
  parameter int AW  = 32,
  parameter int PLW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] offset,
  input logic [AW-1:0] seg_base,
  input logic          seg_present,
  input logic          prot_en,
  input logic          v86,
  input logic          rsp_valid,
  input logic [AW-1:0] lin_addr,
  input logic          fault,
  input logic          fault_np
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lin_addr) && $stable(fault) && $stable(fault_np)));

  assert_addr_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (lin_addr == $past(seg_base + offset)));

  assert_unprotected_no_np_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!prot_en || v86)) |=> !fault_np);

  assert_absent_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_en && !v86 && !seg_present) |=> fault);

  assert_np_implies_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_np |-> fault);
endmodule

bind seg_access_guard seg_access_guard_checker #(.AW(AW), .PLW(PLW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .offset      (offset),
  .seg_base    (seg_base),
  .seg_present (seg_present),
  .prot_en     (prot_en),
  .v86         (v86),
  .rsp_valid   (rsp_valid),
  .lin_addr    (lin_addr),
  .fault       (fault),
  .fault_np    (fault_np)
);

// File: tb/seg_access_guard_test.sv
module seg_access_guard_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  acc_kind;
  logic [31:0] offset;
  logic [2:0]  acc_size;
  logic [31:0] seg_base;
  logic [31:0] seg_limit;
  logic        seg_present;
  logic [1:0]  seg_dpl;
  logic [1:0]  seg_rpl;
  logic        seg_exec;
  logic        seg_rw;
  logic        seg_dir;
  logic [1:0]  cpl;
  logic        prot_en;
  logic        v86;
  logic        rsp_valid;
  logic [31:0] lin_addr;
  logic        fault;
  logic        fault_np;

  int checks = 0;
  int errors = 0;

  seg_access_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .offset(offset), .acc_size(acc_size), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_present(seg_present), .seg_dpl(seg_dpl),
    .seg_rpl(seg_rpl), .seg_exec(seg_exec), .seg_rw(seg_rw),
    .seg_dir(seg_dir), .cpl(cpl), .prot_en(prot_en), .v86(v86),
    .rsp_valid(rsp_valid), .lin_addr(lin_addr), .fault(fault),
    .fault_np(fault_np)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  function automatic void model(output bit f, output bit np, output string tag);
    bit fetch;
    bit rd;
    bit wr;
    bit down;
    bit lim;
    longint last;
    fetch = acc_kind == 2'd0;
    rd    = acc_kind == 2'd1;
    wr    = acc_kind >= 2'd2;
    down  = !fetch && !seg_exec && seg_dir;
    last  = longint'(offset) + longint'(acc_size) - 1;
    lim   = down ? (offset < seg_limit) : (last > longint'(seg_limit));
    f = 1'b0; np = 1'b0; tag = "R11";
    if (lim) begin f = 1'b1; tag = down ? "R4" : "R3"; return; end
    if (!prot_en || v86) begin tag = "R5"; return; end
    if (!seg_present) begin f = 1'b1; np = 1'b1; tag = "R6"; return; end
    if ((cpl > seg_dpl) || (!fetch && seg_rpl > seg_dpl)) begin
      f = 1'b1; tag = "R7"; return;
    end
    if ((fetch && !seg_exec) || (rd && seg_exec && !seg_rw)) begin
      f = 1'b1; tag = "R8"; return;
    end
    if (wr && (seg_exec || !seg_rw)) begin f = 1'b1; tag = "R9"; return; end
  endfunction

  // Inputs are already applied at a falling edge with req_valid high.
  task automatic step_and_check();
    bit ef;
    bit en;
    string tg;
    logic [31:0] ea;
    model(ef, en, tg);
    if (acc_kind == 2'd3) tg = {"R10/", tg};
    ea = seg_base + offset;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R1 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(lin_addr == ea, "R2 lin_addr", 64'(lin_addr), 64'(ea));
    chk({fault, fault_np} == {ef, en}, tg, 64'({fault, fault_np}), 64'({ef, en}));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; req_valid = 1'b0; acc_kind = '0; offset = '0; acc_size = 3'd1;
    seg_base = '0; seg_limit = '0; seg_present = 1'b1; seg_dpl = '0;
    seg_rpl = '0; seg_exec = 1'b0; seg_rw = 1'b1; seg_dir = 1'b0; cpl = '0;
    prot_en = 1'b0; v86 = 1'b0;
    repeat (3) @(negedge clk);
    chk({rsp_valid, fault, fault_np} == 3'b000 && lin_addr == 32'd0,
        "R1 reset state", 64'({rsp_valid, fault, fault_np, lin_addr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: limit 0x100, four offset/size positions around it.
    seg_limit = 32'h0000_0100;
    for (int pos = 0; pos < 4; pos++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int k = 0; k < 4; k++) begin
          for (int ty = 0; ty < 8; ty++) begin
            for (int pr = 0; pr < 2; pr++) begin
              for (int dl = 0; dl < 4; dl++) begin
                for (int cl = 0; cl < 4; cl++) begin
                  for (int rl = 0; rl < 2; rl++) begin
                    case (pos)
                      0: begin offset = 32'h0000_00FD; acc_size = 3'd4; end
                      1: begin offset = 32'h0000_00FE; acc_size = 3'd4; end
                      2: begin offset = 32'h0000_0100; acc_size = 3'd1; end
                      default: begin offset = 32'h0000_0200; acc_size = 3'd2; end
                    endcase
                    prot_en     = mode != 0;
                    v86         = mode == 2;
                    acc_kind    = 2'(k);
                    seg_exec    = ty[2];
                    seg_rw      = ty[1];
                    seg_dir     = ty[0];
                    seg_present = pr[0];
                    seg_dpl     = 2'(dl);
                    cpl         = 2'(cl);
                    seg_rpl     = rl[0] ? 2'd3 : 2'd0;
                    seg_base    = cl[0] ? 32'hFFFF_FF80 : 32'h0001_0000;
                    req_valid   = 1'b1;
                    step_and_check();
                  end
                end
              end
            end
          end
        end
      end
    end

    // R3: end-of-access sum must not wrap around 2^32.
    prot_en = 1'b0; v86 = 1'b0; acc_kind = 2'd1; seg_exec = 1'b0; seg_dir = 1'b0;
    seg_limit = 32'hFFFF_FFFF; offset = 32'hFFFF_FFFF; acc_size = 3'd2;
    seg_base = 32'h0000_0001;
    step_and_check();
    acc_size = 3'd1;
    step_and_check();

    // R1: outputs hold while no request is made.
    held = lin_addr;
    req_valid = 1'b0; offset = 32'h1234_5678; seg_base = 32'h0BAD_0000;
    acc_size = 3'd7; seg_limit = 32'd0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk(lin_addr == held && fault == 1'b0, "R1 idle hold",
        64'({fault, lin_addr}), 64'({1'b0, held}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule